// File: doc/BRIEF.md
# Binary-Field Inverse and Product Unit

This block computes, in the binary extension field GF(2^M), either the product of two elements or the multiplicative inverse of one element. The field is defined by a fixed irreducible polynomial of degree M, given as the parameter `POLY`. Both operations run on one shared register set and one XOR/shift network. The network is unrolled W bit-steps deep, so each clock cycle advances the running algorithm by one digit of W bits.

Multiplication scans the multiplier `b` from bit 0 upward. When the current bit is set, the running sum absorbs the multiplicand. The multiplicand is then multiplied by x and reduced by `POLY`. Inversion runs a constant-time binary extended Euclidean iteration driven by a signed degree-difference counter. It always runs for 2M-1 bit-steps, whatever the input, and it reads the inverse from its cofactor register. The opcode `op` selects the operation when `start` is pulsed.

A caller pulses `start` while `busy` is low. The result appears on `result` with a one-cycle `done` pulse, and `result` holds until the next operation completes. The block has no output back-pressure: because the result is held, a consumer may read it at any later time. A new operation may be accepted in the cycle in which `done` is high.

Top module: `binfield_alu`

## Requirements
- R1: With `op`=0, an accepted start yields `result` = a·b reduced modulo `POLY`, with `done` high exactly ceil(M/W) rising edges after the accepting edge (2 edges for M=8, W=4).
- R2: With `op`=1 and nonzero `a`, an accepted start yields `result` = a⁻¹, the element whose product with `a` modulo `POLY` is 1, with `done` high exactly ceil((2M-1)/W) rising edges after the accepting edge (4 for M=8, W=4).
- R3: Inverting zero takes the same number of cycles as R2 and returns 0.
- R4: After reset, `result` is 0 and `busy` and `done` are low. `busy` rises only on the edge after an accepted start, stays high until the completion edge, and is low whenever `done` is high.
- R5: A `start` seen while `busy` is high is ignored: the running operation keeps its operands, opcode, latency and result, and no extra `done` occurs.
- R6: `done` lasts one cycle per operation, and `result` changes only on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a new operation; sampled only while `busy` is low |
| op | input | 1 | Operation select: 0 multiply a·b, 1 invert a |
| a | input | M | First operand (element to invert when `op`=1) |
| b | input | M | Multiplier (ignored when `op`=1) |
| result | output | M | Last completed result, held until the next completion |
| done | output | 1 | One-cycle pulse marking a new `result` |
| busy | output | 1 | High while an operation is running |

## Verification
On every cycle the bound checker enforces the latency of each operation, measured from the accepting edge. It also checks that an inverted zero returns zero, that `done` is a single-cycle pulse that never coincides with `busy`, that `busy` rises only after a start, and that `result` holds between completions. The numerical correctness of products and inverses can be shown only by the bench's scenarios: a bitwise schoolbook reference for products, a search-based reference for every nonzero inverse in the default field, and a scenario that pulses `start` with different operands during a running inversion.

// File: rtl/binfield_pkg.sv
package binfield_pkg;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_INV = 1'b1
  } op_e;

  // Integer ceiling division used for cycle counts.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/binfield_step.sv
// One bit-level step of the shared datapath. Multiply mode: conditional
// accumulate, multiplicand times x mod POLY, multiplier shifted right.
// Invert mode: one constant-time divstep on (f,g) with cofactors (acc,aux).
module binfield_step
  import binfield_pkg::*;
#(
  parameter int         M    = 8,
  parameter logic [M:0] POLY = 9'h11B,
  parameter int         DW   = 7
) (
  input  op_e                   op,
  input  logic [M:0]            f_i,
  input  logic [M:0]            g_i,
  input  logic [M-1:0]          acc_i,
  input  logic [M-1:0]          aux_i,
  input  logic signed [DW-1:0]  dl_i,
  output logic [M:0]            f_o,
  output logic [M:0]            g_o,
  output logic [M-1:0]          acc_o,
  output logic [M-1:0]          aux_o,
  output logic signed [DW-1:0]  dl_o
);

  localparam logic signed [DW-1:0] ONE = DW'(1);

  logic [M-1:0] sum_acc;
  logic [M:0]   up;
  logic [M-1:0] xmul;
  logic [M:0]   g_mix;
  logic [M-1:0] bsel;
  logic [M:0]   dv;
  logic [M-1:0] xdiv;
  logic         swap;

  always_comb begin
    // Shared XOR of the two cofactor / accumulator registers.
    sum_acc = acc_i ^ aux_i;

    // Multiply by x, reduce when degree M appears.
    up = {aux_i, 1'b0};
    if (up[M]) up = up ^ POLY;
    xmul = up[M-1:0];

    // Clear the low bit of g using f when needed, then halve.
    g_mix = g_i[0] ? (g_i ^ f_i) : g_i;

    // Divide by x modulo POLY (POLY has constant term 1).
    bsel = g_i[0] ? sum_acc : aux_i;
    dv   = {1'b0, bsel};
    if (dv[0]) dv = dv ^ POLY;
    xdiv = dv[M:1];

    swap = g_i[0] && (dl_i > 0);

    if (op == OP_MUL) begin
      f_o   = f_i;
      g_o   = g_i >> 1;
      acc_o = g_i[0] ? sum_acc : acc_i;
      aux_o = xmul;
      dl_o  = dl_i;
    end else begin
      f_o   = swap ? g_i : f_i;
      g_o   = g_mix >> 1;
      acc_o = swap ? aux_i : acc_i;
      aux_o = xdiv;
      dl_o  = swap ? (ONE - dl_i) : (dl_i + ONE);
    end
  end

endmodule

// File: rtl/binfield_digit.sv
// W chained bit-steps: one clock cycle of work.
module binfield_digit
  import binfield_pkg::*;
#(
  parameter int         M    = 8,
  parameter int         W    = 4,
  parameter logic [M:0] POLY = 9'h11B,
  parameter int         DW   = 7
) (
  input  op_e                   op,
  input  logic [M:0]            f_i,
  input  logic [M:0]            g_i,
  input  logic [M-1:0]          acc_i,
  input  logic [M-1:0]          aux_i,
  input  logic signed [DW-1:0]  dl_i,
  output logic [M:0]            f_o,
  output logic [M:0]            g_o,
  output logic [M-1:0]          acc_o,
  output logic [M-1:0]          aux_o,
  output logic signed [DW-1:0]  dl_o
);

  logic [M:0]           f_s   [W+1];
  logic [M:0]           g_s   [W+1];
  logic [M-1:0]         acc_s [W+1];
  logic [M-1:0]         aux_s [W+1];
  logic signed [DW-1:0] dl_s  [W+1];

  assign f_s[0]   = f_i;
  assign g_s[0]   = g_i;
  assign acc_s[0] = acc_i;
  assign aux_s[0] = aux_i;
  assign dl_s[0]  = dl_i;

  for (genvar k = 0; k < W; k++) begin : g_chain
    binfield_step #(.M(M), .POLY(POLY), .DW(DW)) u_step (
      .op    (op),
      .f_i   (f_s[k]),
      .g_i   (g_s[k]),
      .acc_i (acc_s[k]),
      .aux_i (aux_s[k]),
      .dl_i  (dl_s[k]),
      .f_o   (f_s[k+1]),
      .g_o   (g_s[k+1]),
      .acc_o (acc_s[k+1]),
      .aux_o (aux_s[k+1]),
      .dl_o  (dl_s[k+1])
    );
  end

  assign f_o   = f_s[W];
  assign g_o   = g_s[W];
  assign acc_o = acc_s[W];
  assign aux_o = aux_s[W];
  assign dl_o  = dl_s[W];

endmodule

// File: rtl/binfield_ctrl.sv
// Sequencer: accepts a start when idle and counts digit cycles.
module binfield_ctrl
  import binfield_pkg::*;
#(
  parameter int NMUL = 2,
  parameter int NINV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  op_e  op,
  output logic accept,
  output logic busy,
  output logic last,
  output op_e  op_q
);

  localparam int NMAX = (NINV > NMUL) ? NINV : NMUL;
  localparam int CW   = $clog2(NMAX + 1) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  assign accept = start && !busy;
  assign lim_m1 = (op_q == OP_INV) ? CW'(NINV - 1) : CW'(NMUL - 1);
  assign last   = busy && (cnt == lim_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      op_q <= OP_MUL;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
      op_q <= op;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/binfield_alu.sv
// Unified digit-serial GF(2^M) multiplier / inverter.
module binfield_alu
  import binfield_pkg::*;
#(
  parameter int         M    = 8,
  parameter int         W    = 4,
  parameter logic [M:0] POLY = 9'h11B
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] result,
  output logic         done,
  output logic         busy
);

  localparam int NMUL = ceil_div(M, W);
  localparam int NINV = ceil_div(2 * M - 1, W);
  localparam int DW   = $clog2(2 * M + W) + 2;

  op_e  op_in;
  op_e  op_q;
  logic accept;
  logic last;

  logic [M:0]           f_q,   g_q;
  logic [M-1:0]         acc_q, aux_q;
  logic signed [DW-1:0] dl_q;

  logic [M:0]           f_n,   g_n;
  logic [M-1:0]         acc_n, aux_n;
  logic signed [DW-1:0] dl_n;

  logic [M-1:0] res_q;
  logic         done_q;

  assign op_in = op_e'(op);

  binfield_ctrl #(.NMUL(NMUL), .NINV(NINV)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op     (op_in),
    .accept (accept),
    .busy   (busy),
    .last   (last),
    .op_q   (op_q)
  );

  binfield_digit #(.M(M), .W(W), .POLY(POLY), .DW(DW)) u_digit (
    .op    (op_q),
    .f_i   (f_q),
    .g_i   (g_q),
    .acc_i (acc_q),
    .aux_i (aux_q),
    .dl_i  (dl_q),
    .f_o   (f_n),
    .g_o   (g_n),
    .acc_o (acc_n),
    .aux_o (aux_n),
    .dl_o  (dl_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q    <= '0;
      g_q    <= '0;
      acc_q  <= '0;
      aux_q  <= '0;
      dl_q   <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        acc_q <= '0;
        if (op_in == OP_INV) begin
          // f = POLY (cofactor 0), g = a (cofactor 1), delta = 1
          f_q   <= POLY;
          g_q   <= {1'b0, a};
          aux_q <= M'(1);
          dl_q  <= DW'(1);
        end else begin
          // g holds the multiplier, aux the multiplicand
          f_q   <= '0;
          g_q   <= {1'b0, b};
          aux_q <= a;
          dl_q  <= '0;
        end
      end else if (busy) begin
        f_q   <= f_n;
        g_q   <= g_n;
        acc_q <= acc_n;
        aux_q <= aux_n;
        dl_q  <= dl_n;
      end
      if (last) res_q <= acc_n;
    end
  end

  assign result = res_q;
  assign done   = done_q;

endmodule

// File: rtl/binfield_alu_chk.sv
// Cycle-level checker attached to binfield_alu.
module binfield_alu_chk #(
  parameter int M = 8,
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         op,
  input logic [M-1:0] a,
  input logic         busy,
  input logic         done,
  input logic [M-1:0] result
);

  localparam int NMUL = (M + W - 1) / W;
  localparam int NINV = (2 * M - 1 + W - 1) / W;
  localparam int CW   = $clog2(NINV + 2) + 1;

  logic [CW-1:0] cyc;
  logic          run;
  logic          op_r;
  logic          zero_r;
  logic          acc_now;

  assign acc_now = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc    <= '0;
      run    <= 1'b0;
      op_r   <= 1'b0;
      zero_r <= 1'b0;
    end else if (acc_now) begin
      cyc    <= '0;
      run    <= 1'b1;
      op_r   <= op;
      zero_r <= (a == '0);
    end else if (done) begin
      run <= 1'b0;
    end else if (run && cyc < CW'(NINV + 1)) begin
      cyc <= cyc + CW'(1);
    end
  end

  assert_mul_latency_R1: assert property (@(posedge clk) disable iff (rst)
    done && !op_r |-> run && cyc == CW'(NMUL));

  assert_inv_latency_R2: assert property (@(posedge clk) disable iff (rst)
    done && op_r |-> run && cyc == CW'(NINV));

  assert_zero_inverse_R3: assert property (@(posedge clk) disable iff (rst)
    done && op_r && zero_r |-> result == '0);

  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done && !acc_now |=> !done);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> result == $past(result));

endmodule

bind binfield_alu binfield_alu_chk #(.M(M), .W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .op     (op),
  .a      (a),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/binfield_alu_test.sv
module binfield_alu_test;

  localparam int         M       = 8;
  localparam int         W       = 4;
  localparam logic [M:0] POLY    = 9'h11B;
  localparam int         LAT_MUL = (M + W - 1) / W;
  localparam int         LAT_INV = (2 * M - 1 + W - 1) / W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         op = 1'b0;
  logic [M-1:0] a = '0;
  logic [M-1:0] b = '0;
  logic [M-1:0] result;
  logic         done;
  logic         busy;

  always #5 clk = ~clk;

  binfield_alu #(.M(M), .W(W), .POLY(POLY)) uut (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op     (op),
    .a      (a),
    .b      (b),
    .result (result),
    .done   (done),
    .busy   (busy)
  );

  typedef struct {
    logic [M-1:0] exp;
    int           lat;
    int           acc_edge;
    string        tag;
  } item_t;

  item_t        sb[$];
  int           checks = 0;
  int           fails = 0;
  int           edge_cnt = 0;
  logic [M-1:0] prev_res = '0;
  logic         prev_done = 1'b0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  // Schoolbook product followed by long-division reduction.
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [2*M-2:0] p;
    p = '0;
    for (int i = 0; i < M; i++)
      if (y[i]) p = p ^ ((2*M-1)'(x) << i);
    for (int k = 2*M-2; k >= M; k--)
      if (p[k]) p = p ^ ((2*M-1)'(POLY) << (k - M));
    return p[M-1:0];
  endfunction

  // Inverse by exhaustive search; zero maps to zero.
  function automatic logic [M-1:0] ref_inv(input logic [M-1:0] x);
    for (int c = 1; c < (1 << M); c++)
      if (ref_mul(x, M'(c)) == M'(1)) return M'(c);
    return '0;
  endfunction

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Driver: call just after a falling edge.
  task automatic issue(input logic o, input logic [M-1:0] x, input logic [M-1:0] y,
                       input string tag);
    item_t it;
    while (busy) @(negedge clk);
    it.exp      = o ? ref_inv(x) : ref_mul(x, y);
    it.lat      = o ? LAT_INV : LAT_MUL;
    it.acc_edge = edge_cnt + 1;
    it.tag      = tag;
    sb.push_back(it);
    start = 1'b1;
    op    = o;
    a     = x;
    b     = y;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: pops the scoreboard on every done pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R5 done with no pending operation", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(result == it.exp, {it.tag, " result"}, int'(result), int'(it.exp));
          chk(edge_cnt - it.acc_edge == it.lat, {it.tag, " latency"},
              edge_cnt - it.acc_edge, it.lat);
        end
        if (prev_done) chk(1'b0, "R6 done wider than one cycle", 1, 0);
      end else if (result !== prev_res) begin
        chk(1'b0, "R6 result moved without done", int'(result), int'(prev_res));
      end
      prev_res  = result;
      prev_done = done;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired: actual=busy expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [M-1:0] s1;
    logic [M-1:0] s2;
    item_t        it;
    repeat (3) @(negedge clk);
    // R4: reset state
    chk(result == '0, "R4 result after reset", int'(result), 0);
    chk(busy == 1'b0, "R4 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R4 done after reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1: directed products
    issue(1'b0, 8'h57, 8'h83, "R1 mul 57*83");
    issue(1'b0, 8'hA5, 8'h01, "R1 mul by one");
    issue(1'b0, 8'h3C, 8'h00, "R1 mul by zero");
    issue(1'b0, 8'hFF, 8'hFF, "R1 mul ff*ff");
    issue(1'b0, 8'h80, 8'h02, "R1 mul reduce");
    issue(1'b0, 8'h01, 8'h80, "R1 mul top bit");
    // R1: pseudo-random products
    s1 = 8'h1D;
    s2 = 8'hC7;
    for (int i = 0; i < 40; i++) begin
      s1 = s1 * 8'd37 + 8'd11;
      s2 = s2 * 8'd13 + 8'd101;
      issue(1'b0, s1, s2, "R1 mul random");
    end

    // R2: every nonzero inverse, back to back
    for (int i = 1; i < (1 << M); i++)
      issue(1'b1, M'(i), M'(i ^ 8'h5A), "R2 inv");

    // R3: zero input
    issue(1'b1, '0, 8'hFF, "R3 inv zero");
    while (sb.size() != 0) @(negedge clk);

    // R4 and R5: start pulsed again while an inversion runs
    while (busy) @(negedge clk);
    it.exp      = ref_inv(8'h35);
    it.lat      = LAT_INV;
    it.acc_edge = edge_cnt + 1;
    it.tag      = "R5 inv with ignored start";
    sb.push_back(it);
    start = 1'b1;
    op    = 1'b1;
    a     = 8'h35;
    b     = 8'h00;
    @(negedge clk);
    chk(busy == 1'b1, "R4 busy after accept", int'(busy), 1);
    op = 1'b0;
    a  = 8'h12;
    b  = 8'h34;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (LAT_INV + 3) @(negedge clk);
    chk(sb.size() == 0, "R5 no extra operation", sb.size(), 0);
    chk(result == ref_inv(8'h35), "R5 result kept", int'(result), int'(ref_inv(8'h35)));
    chk(busy == 1'b0, "R5 idle after ignored start", int'(busy), 0);
    chk(done == 1'b0, "R6 done low while idle", int'(done), 0);

    summary();
    $finish;
  end

endmodule